// File: doc/BRIEF.md
# Clock Prescaler and Source Selector

This block manages the clocks of a small processor core from a single fast reference clock. It never gates a clock. It produces two single-cycle enable strobes on the reference clock. The internal strobe marks the internal clock. The CPU strobe marks the slower processor clock. The internal strobe can be the reference halved or passed straight through. The CPU strobe comes from a programmable prescaler applied to the internal strobe.

Software can ask to run from an alternate low-speed clock input. The switch is made only when a watchdog window has seen that input toggle. A status output tells software whether the switch has really happened.

The block also has two wait modes entered by a wait-for-interrupt request:
- a plain wait, which only freezes the CPU strobe;
- a low-power wait, which slows the internal strobe or moves it onto the alternate clock.

A halt request either stops everything until reset or, when enabled, becomes a one-cycle software reset pulse. Two 8-bit registers are written and read over a small register bus.

Top module: `clkmgr_ctrl`

## Requirements
- R1: After reset, the mode register (bus_sel=0) reads 0xE0 and the control register (bus_sel=1) reads 0x00. With no alternate clock present, the internal strobe then pulses on every second reference cycle and the CPU strobe coincides with it.
- R2: A write takes effect at the clock edge on which bus_wr is high. bus_rdata always shows the register chosen by bus_sel. Every bit reads back as written, including the reserved control bits 6:4.
- R3: When mode bit 5 is 1, the internal strobe pulses once every two reference cycles. When mode bit 5 is 0, it pulses on every reference cycle.
- R4: Mode bits 4:2 hold the prescale value N. The CPU strobe pulses on every (N+1)-th internal strobe and always together with one. With N=0 it equals the internal strobe.
- R5: A new prescale value is taken up only at the next terminal count of the CPU divider. The pulse that ends the current period keeps the old spacing.
- R6: The alternate input is recognised as rising when it is sampled high at one reference edge after a low sample at the edge before. The presence flag sets at the second reference edge after the high sample. A 64-cycle window runs from reset. At the end of a window the flag clears if no rising edge was recognised inside that window.
- R7: alt_clk_active is control bit 2 AND presence. While it is 1, the internal strobe pulses once per recognised alternate rising edge, and mode bit 5 has no effect. If control bit 2 is set with no alternate clock present, the reference path stays in use and alt_clk_active stays 0.
- R8: A wfi_req accepted with control bit 0 = 0 stops the CPU strobe. The internal strobe carries on unchanged.
- R9: A wfi_req accepted with control bit 0 = 1 enters low-power wait and sets low_power_o. If the alternate clock is not in use, the internal strobe then pulses once per 16 pulses of the (optionally halved) reference.
- R10: Entering low-power wait with control bit 1 = 1 sets control bit 2 in hardware, so the alternate clock is used if present. The bit, and the alternate clock, stay selected after wake-up until software clears bit 2. A bus write in the same cycle takes precedence over this hardware set.
- R11: In either wait mode, the block returns to run on the first internal strobe seen while wake_in is high. CPU strobes resume from the next cycle.
- R12: A halt_req accepted in run with control bit 3 = 1 gives a one-cycle soft_rst_o pulse in the following cycle, and the block stays in run. With control bit 3 = 0 it sets halted_o and silences both strobes until reset. Halt takes priority over a simultaneous wfi_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Register select: 0 mode, 1 control |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register |
| alt_clk_in | input | 1 | Alternate low-speed clock, asynchronous |
| wfi_req | input | 1 | Wait-for-interrupt request, one cycle |
| wake_in | input | 1 | Wake request from the interrupt side |
| halt_req | input | 1 | Halt request, one cycle |
| int_clk_en | output | 1 | Internal clock enable strobe |
| cpu_clk_en | output | 1 | CPU clock enable strobe |
| alt_clk_active | output | 1 | Alternate clock actually in use |
| low_power_o | output | 1 | Low-power wait in progress |
| halted_o | output | 1 | Halted, waiting for reset |
| soft_rst_o | output | 1 | One-cycle software reset pulse |

## Verification
The bench changes the prescale value in the middle of a period. A design that reloads at once, and not at the terminal count, would produce a short CPU period. It asks for the alternate clock both while the input toggles and while it is idle. A detector that trusts the select bit alone would stop the internal strobe dead. It also stops the alternate input and waits two windows: a presence flag that never clears would leave the block running with no strobes. The low-power wait is entered with both wait-clock settings and left again. This catches a wrong divide-by-16 rate, a missing hardware set of the select bit, and a design that drops back to the reference after wake-up. Halt is tried with and without the reset enable, which exposes a halt that ignores the enable or one that still lets strobes through.

// File: rtl/clkmgr_pkg.sv
package clkmgr_pkg;

  localparam int unsigned REG_W = 8;
  localparam int unsigned PRS_W = 3;

  // mode register fields
  localparam int unsigned MODE_HALVE_BIT = 5;
  localparam int unsigned MODE_PRS_LSB   = 2;
  localparam logic [REG_W-1:0] MODE_RST_VAL = 8'hE0;

  // control register fields
  localparam int unsigned CTL_LPW_BIT  = 0;
  localparam int unsigned CTL_WSEL_BIT = 1;
  localparam int unsigned CTL_ALT_BIT  = 2;
  localparam int unsigned CTL_SRST_BIT = 3;
  localparam logic [REG_W-1:0] CTL_RST_VAL = 8'h00;

  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_WAIT   = 2'd1,
    ST_LPWAIT = 2'd2,
    ST_HALT   = 2'd3
  } run_state_e;

endpackage

// File: rtl/clkmgr_regs.sv
module clkmgr_regs
  import clkmgr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             sel_i,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             hw_alt_set_i,
  output logic [REG_W-1:0] rdata_o,
  output logic             halve_o,
  output logic [PRS_W-1:0] prs_o,
  output logic             lpw_o,
  output logic             wsel_o,
  output logic             altsel_o,
  output logic             srst_o
);

  logic [REG_W-1:0] mode_q, mode_d;
  logic [REG_W-1:0] ctl_q, ctl_d;

  always_comb begin
    mode_d = mode_q;
    ctl_d  = ctl_q;
    if (wr_i && !sel_i) begin
      mode_d = wdata_i;
    end
    // software write outranks the hardware set of the select bit
    if (wr_i && sel_i) begin
      ctl_d = wdata_i;
    end else if (hw_alt_set_i) begin
      ctl_d[CTL_ALT_BIT] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_RST_VAL;
      ctl_q  <= CTL_RST_VAL;
    end else begin
      mode_q <= mode_d;
      ctl_q  <= ctl_d;
    end
  end

  assign rdata_o  = sel_i ? ctl_q : mode_q;
  assign halve_o  = mode_q[MODE_HALVE_BIT];
  assign prs_o    = mode_q[MODE_PRS_LSB +: PRS_W];
  assign lpw_o    = ctl_q[CTL_LPW_BIT];
  assign wsel_o   = ctl_q[CTL_WSEL_BIT];
  assign altsel_o = ctl_q[CTL_ALT_BIT];
  assign srst_o   = ctl_q[CTL_SRST_BIT];

endmodule

// File: rtl/clkmgr_alt_detect.sv
module clkmgr_alt_detect #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned WINDOW      = 64
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic alt_i,
  output logic rise_o,
  output logic present_o
);

  localparam int unsigned WCW = $clog2(WINDOW);
  localparam logic [WCW-1:0] WIN_LAST = WCW'(WINDOW - 1);

  // synchronizer stages plus one history stage for edge detection
  logic [SYNC_STAGES:0] chain_q;
  logic [WCW-1:0]       win_q, win_d;
  logic                 seen_q, seen_d;
  logic                 present_q, present_d;

  assign rise_o = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];

  always_comb begin
    win_d     = win_q;
    seen_d    = seen_q;
    present_d = present_q;
    if (win_q == WIN_LAST) begin
      win_d     = '0;
      present_d = seen_q | rise_o;
      seen_d    = 1'b0;
    end else begin
      win_d = win_q + 1'b1;
      if (rise_o) begin
        present_d = 1'b1;
        seen_d    = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q   <= '0;
      win_q     <= '0;
      seen_q    <= 1'b0;
      present_q <= 1'b0;
    end else begin
      chain_q   <= {chain_q[SYNC_STAGES-1:0], alt_i};
      win_q     <= win_d;
      seen_q    <= seen_d;
      present_q <= present_d;
    end
  end

  assign present_o = present_q;

endmodule

// File: rtl/clkmgr_clkgen.sv
module clkmgr_clkgen #(
  parameter int unsigned PRS_W  = 3,
  parameter int unsigned LP_DIV = 16
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             halve_i,
  input  logic [PRS_W-1:0] prs_i,
  input  logic             use_alt_i,
  input  logic             alt_rise_i,
  input  logic             lp_mode_i,
  input  logic             stop_i,
  input  logic             cpu_allow_i,
  output logic             int_en_o,
  output logic             cpu_en_o
);

  localparam int unsigned LCW = (LP_DIV > 1) ? $clog2(LP_DIV) : 1;
  localparam logic [LCW-1:0] LP_LAST = LCW'(LP_DIV - 1);

  logic             phase_q;
  logic [LCW-1:0]   lp_cnt_q, lp_cnt_d, lp_inc;
  logic [PRS_W-1:0] pre_cnt_q, pre_cnt_d;
  logic [PRS_W-1:0] prs_act_q, prs_act_d;
  logic             base_en, pre_tc;

  assign base_en = halve_i ? phase_q : 1'b1;

  // low-power counter wrap: free wrap for powers of two, compare otherwise
  if ((LP_DIV & (LP_DIV - 1)) == 0) begin : g_lp_pow2
    assign lp_inc = lp_cnt_q + 1'b1;
  end else begin : g_lp_cmp
    assign lp_inc = (lp_cnt_q == LP_LAST) ? '0 : lp_cnt_q + 1'b1;
  end

  always_comb begin
    if (stop_i) begin
      int_en_o = 1'b0;
    end else if (use_alt_i) begin
      int_en_o = alt_rise_i;
    end else if (lp_mode_i) begin
      int_en_o = base_en && (lp_cnt_q == LP_LAST);
    end else begin
      int_en_o = base_en;
    end
  end

  assign pre_tc   = (pre_cnt_q == prs_act_q);
  assign cpu_en_o = int_en_o && pre_tc && cpu_allow_i;

  always_comb begin
    lp_cnt_d  = lp_cnt_q;
    pre_cnt_d = pre_cnt_q;
    prs_act_d = prs_act_q;
    if (!lp_mode_i) begin
      lp_cnt_d = '0;
    end else if (base_en && !use_alt_i) begin
      lp_cnt_d = lp_inc;
    end
    if (int_en_o) begin
      if (pre_tc) begin
        pre_cnt_d = '0;
        prs_act_d = prs_i;
      end else begin
        pre_cnt_d = pre_cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= 1'b0;
      lp_cnt_q  <= '0;
      pre_cnt_q <= '0;
      prs_act_q <= '0;
    end else begin
      phase_q   <= ~phase_q;
      lp_cnt_q  <= lp_cnt_d;
      pre_cnt_q <= pre_cnt_d;
      prs_act_q <= prs_act_d;
    end
  end

endmodule

// File: rtl/clkmgr_ctrl.sv
module clkmgr_ctrl
  import clkmgr_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned WINDOW      = 64,
  parameter int unsigned LP_DIV      = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_sel,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       alt_clk_in,
  input  logic       wfi_req,
  input  logic       wake_in,
  input  logic       halt_req,
  output logic       int_clk_en,
  output logic       cpu_clk_en,
  output logic       alt_clk_active,
  output logic       low_power_o,
  output logic       halted_o,
  output logic       soft_rst_o
);

  logic [1:0]       rst_sync_q;
  logic             rst_ni;
  run_state_e       state_q, state_d;
  logic             srst_q, srst_d;
  logic             hw_alt_set;
  logic             halve_bit, lpw_bit, wsel_bit, altsel_bit, srst_bit;
  logic [PRS_W-1:0] prs_val;
  logic             alt_rise, alt_present, use_alt;

  // reset: asserted asynchronously, released after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_ni = rst_sync_q[1];

  clkmgr_regs u_regs (
    .clk          (clk),
    .rst_ni       (rst_ni),
    .sel_i        (bus_sel),
    .wr_i         (bus_wr),
    .wdata_i      (bus_wdata),
    .hw_alt_set_i (hw_alt_set),
    .rdata_o      (bus_rdata),
    .halve_o      (halve_bit),
    .prs_o        (prs_val),
    .lpw_o        (lpw_bit),
    .wsel_o       (wsel_bit),
    .altsel_o     (altsel_bit),
    .srst_o       (srst_bit)
  );

  clkmgr_alt_detect #(
    .SYNC_STAGES (SYNC_STAGES),
    .WINDOW      (WINDOW)
  ) u_alt (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .alt_i     (alt_clk_in),
    .rise_o    (alt_rise),
    .present_o (alt_present)
  );

  assign use_alt = altsel_bit & alt_present;

  clkmgr_clkgen #(
    .PRS_W  (PRS_W),
    .LP_DIV (LP_DIV)
  ) u_gen (
    .clk         (clk),
    .rst_ni      (rst_ni),
    .halve_i     (halve_bit),
    .prs_i       (prs_val),
    .use_alt_i   (use_alt),
    .alt_rise_i  (alt_rise),
    .lp_mode_i   (state_q == ST_LPWAIT),
    .stop_i      (state_q == ST_HALT),
    .cpu_allow_i (state_q == ST_RUN),
    .int_en_o    (int_clk_en),
    .cpu_en_o    (cpu_clk_en)
  );

  always_comb begin
    state_d    = state_q;
    srst_d     = 1'b0;
    hw_alt_set = 1'b0;
    unique case (state_q)
      ST_RUN: begin
        if (halt_req) begin
          if (srst_bit) begin
            srst_d = 1'b1;
          end else begin
            state_d = ST_HALT;
          end
        end else if (wfi_req) begin
          if (lpw_bit) begin
            state_d    = ST_LPWAIT;
            hw_alt_set = wsel_bit;
          end else begin
            state_d = ST_WAIT;
          end
        end
      end
      ST_WAIT, ST_LPWAIT: begin
        if (wake_in && int_clk_en) begin
          state_d = ST_RUN;
        end
      end
      default: state_d = ST_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      srst_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      srst_q  <= srst_d;
    end
  end

  assign alt_clk_active = use_alt;
  assign low_power_o    = (state_q == ST_LPWAIT);
  assign halted_o       = (state_q == ST_HALT);
  assign soft_rst_o     = srst_q;

endmodule

// File: rtl/clkmgr_ctrl_checker.sv
module clkmgr_ctrl_checker
  import clkmgr_pkg::*;
(
  input logic       clk,
  input logic       rst_ni,
  input logic       int_clk_en,
  input logic       cpu_clk_en,
  input logic       halted_o,
  input logic       soft_rst_o,
  input logic       halt_req,
  input logic       wfi_req,
  input logic       bus_wr,
  input logic       bus_sel,
  input logic       halve_bit,
  input logic       lpw_bit,
  input logic       wsel_bit,
  input logic       altsel_bit,
  input logic       srst_bit,
  input logic       alt_clk_active,
  input run_state_e state_q
);

  assert_cpu_inside_int_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    cpu_clk_en |-> int_clk_en);

  assert_wait_freezes_cpu_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q != ST_RUN) |-> !cpu_clk_en);

  assert_halt_silent_R12: assert property (@(posedge clk) disable iff (!rst_ni)
    halted_o |-> (!int_clk_en && !cpu_clk_en));

  assert_soft_reset_cause_R12: assert property (@(posedge clk) disable iff (!rst_ni)
    soft_rst_o |-> $past(halt_req && srst_bit && state_q == ST_RUN));

  assert_halved_gap_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    (int_clk_en && halve_bit && !alt_clk_active && state_q == ST_RUN)
      |=> (!int_clk_en || alt_clk_active || !halve_bit));

  assert_lp_sets_alt_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_RUN && wfi_req && !halt_req && lpw_bit && wsel_bit
     && !(bus_wr && bus_sel)) |=> altsel_bit);

endmodule

bind clkmgr_ctrl clkmgr_ctrl_checker u_checker (
  .clk            (clk),
  .rst_ni         (rst_ni),
  .int_clk_en     (int_clk_en),
  .cpu_clk_en     (cpu_clk_en),
  .halted_o       (halted_o),
  .soft_rst_o     (soft_rst_o),
  .halt_req       (halt_req),
  .wfi_req        (wfi_req),
  .bus_wr         (bus_wr),
  .bus_sel        (bus_sel),
  .halve_bit      (halve_bit),
  .lpw_bit        (lpw_bit),
  .wsel_bit       (wsel_bit),
  .altsel_bit     (altsel_bit),
  .srst_bit       (srst_bit),
  .alt_clk_active (alt_clk_active),
  .state_q        (state_q)
);

// File: tb/clkmgr_ctrl_bench.sv
`timescale 1ns/100ps
module clkmgr_ctrl_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_sel, bus_wr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       alt_clk_in, wfi_req, wake_in, halt_req;
  logic       int_clk_en, cpu_clk_en, alt_clk_active, low_power_o, halted_o, soft_rst_o;

  int    n_checks = 0;
  int    n_fail   = 0;
  bit    cmp_on   = 1'b0;
  bit    alt_run  = 1'b0;
  bit    done     = 1'b0;
  int    srst_seen = 0;
  string cur_req  = "R1";

  always #2 clk = ~clk;

  clkmgr_ctrl u_clkmgr_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .alt_clk_in(alt_clk_in),
    .wfi_req(wfi_req), .wake_in(wake_in), .halt_req(halt_req),
    .int_clk_en(int_clk_en), .cpu_clk_en(cpu_clk_en),
    .alt_clk_active(alt_clk_active), .low_power_o(low_power_o),
    .halted_o(halted_o), .soft_rst_o(soft_rst_o)
  );

  // ---------------- behavioural reference model ----------------
  logic [7:0] m_mode, m_ctl;
  int m_rel, m_win, m_c16, m_pre, m_pact, m_st, m_phase;
  bit m_present, m_seen, m_srst;
  int m_hist[$];

  function automatic void m_reset();
    m_mode = 8'hE0; m_ctl = 8'h00;
    m_win = 0; m_c16 = 0; m_pre = 0; m_pact = 0; m_st = 0; m_phase = 0;
    m_present = 0; m_seen = 0; m_srst = 0;
    m_hist = '{0, 0, 0};
  endfunction

  function automatic bit m_rise();
    return (m_hist[1] == 1) && (m_hist[2] == 0);
  endfunction
  function automatic bit m_alt();
    return m_ctl[2] && m_present;
  endfunction
  function automatic bit m_base();
    return m_mode[5] ? (m_phase == 1) : 1'b1;
  endfunction
  function automatic bit m_int();
    if (m_st == 3) return 1'b0;
    if (m_alt()) return m_rise();
    if (m_st == 2) return m_base() && (m_c16 == 15);
    return m_base();
  endfunction
  function automatic bit m_cpu();
    return m_int() && (m_pre == m_pact) && (m_st == 0);
  endfunction

  function automatic void m_step();
    bit rise, ua, bse, ie, hwset;
    logic [7:0] omode, octl;
    rise = m_rise(); ua = m_alt(); bse = m_base(); ie = m_int();
    omode = m_mode; octl = m_ctl;
    hwset = (m_st == 0) && !halt_req && wfi_req && octl[0] && octl[1];
    if (m_win == 63) begin
      m_present = m_seen || rise; m_seen = 0; m_win = 0;
    end else begin
      if (rise) begin m_present = 1; m_seen = 1; end
      m_win++;
    end
    m_phase = 1 - m_phase;
    if (m_st != 2) m_c16 = 0;
    else if (bse && !ua) m_c16 = (m_c16 + 1) % 16;
    if (ie) begin
      if (m_pre == m_pact) begin m_pre = 0; m_pact = int'(omode[4:2]); end
      else m_pre++;
    end
    m_srst = (m_st == 0) && halt_req && octl[3];
    case (m_st)
      0: if (halt_req) begin if (!octl[3]) m_st = 3; end
         else if (wfi_req) m_st = octl[0] ? 2 : 1;
      1, 2: if (wake_in && ie) m_st = 0;
      default: ;
    endcase
    if (bus_wr && !bus_sel) m_mode = bus_wdata;
    if (bus_wr && bus_sel) m_ctl = bus_wdata;
    else if (hwset) m_ctl[2] = 1'b1;
    m_hist.push_front(int'(alt_clk_in));
    void'(m_hist.pop_back());
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin m_rel = 0; m_reset(); end
    else if (m_rel < 2) begin m_rel++; m_reset(); end
    else m_step();
  end

  // ---------------- checking ----------------
  task automatic fail_line(string req, string what, int act, int exp);
    n_fail++;
    $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
  endtask

  task automatic chk(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) fail_line(req, what, act, exp);
  endtask

  always @(negedge clk) begin
    if (soft_rst_o === 1'b1) srst_seen++;
    if (cmp_on) begin
      n_checks++;
      if (int_clk_en !== m_int()) fail_line(cur_req, "int_clk_en", int'(int_clk_en), int'(m_int()));
      if (cpu_clk_en !== m_cpu()) fail_line(cur_req, "cpu_clk_en", int'(cpu_clk_en), int'(m_cpu()));
      if (alt_clk_active !== m_alt()) fail_line(cur_req, "alt_clk_active", int'(alt_clk_active), int'(m_alt()));
      if (low_power_o !== (m_st == 2)) fail_line(cur_req, "low_power_o", int'(low_power_o), int'(m_st == 2));
      if (halted_o !== (m_st == 3)) fail_line(cur_req, "halted_o", int'(halted_o), int'(m_st == 3));
      if (soft_rst_o !== m_srst) fail_line(cur_req, "soft_rst_o", int'(soft_rst_o), int'(m_srst));
      if (bus_rdata !== (bus_sel ? m_ctl : m_mode))
        fail_line(cur_req, "bus_rdata", int'(bus_rdata), int'(bus_sel ? m_ctl : m_mode));
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic do_reset();
    @(negedge clk); #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic wr_reg(bit sel, logic [7:0] val);
    @(negedge clk); #1 bus_sel = sel; bus_wdata = val; bus_wr = 1'b1;
    @(negedge clk); #1 bus_wr = 1'b0;
  endtask

  task automatic rd_reg(bit sel, output int val);
    @(negedge clk); #1 bus_sel = sel;
    #1 val = int'(bus_rdata);
  endtask

  task automatic pulse_wfi();
    @(negedge clk); #1 wfi_req = 1'b1;
    @(negedge clk); #1 wfi_req = 1'b0;
  endtask

  task automatic pulse_halt();
    @(negedge clk); #1 halt_req = 1'b1;
    @(negedge clk); #1 halt_req = 1'b0;
  endtask

  task automatic wake_up();
    @(negedge clk); #1 wake_in = 1'b1;
    repeat (40) @(negedge clk);
    #1 wake_in = 1'b0;
  endtask

  task automatic count(int n, output int ni, output int nc);
    ni = 0; nc = 0;
    repeat (n) begin
      @(negedge clk);
      ni += int'(int_clk_en);
      nc += int'(cpu_clk_en);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  // ---------------- main sequence ----------------
  initial begin
    int ni, nc, rv, s0;
    rst_n = 1'b1; bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = 8'h00;
    alt_clk_in = 1'b0; wfi_req = 1'b0; wake_in = 1'b0; halt_req = 1'b0;

    fork
      begin : alt_gen
        int ph;
        ph = 0;
        forever begin
          @(negedge clk); #1;
          if (alt_run) begin
            ph++;
            if (ph == 4) begin alt_clk_in = ~alt_clk_in; ph = 0; end
          end else begin
            alt_clk_in = 1'b0;
          end
        end
      end
    join_none

    #1 rst_n = 1'b0;
    #3 cmp_on = 1'b1;
    do_reset();

    // R1: reset values and default strobe rate
    cur_req = "R1";
    rd_reg(1'b0, rv); chk("R1", "mode reset", rv, 8'hE0);
    rd_reg(1'b1, rv); chk("R1", "ctl reset", rv, 8'h00);
    count(20, ni, nc);
    chk("R1", "int pulses/20", ni, 10);
    chk("R1", "cpu pulses/20", nc, 10);

    // R2: readback including reserved bits
    cur_req = "R2";
    wr_reg(1'b1, 8'h70);
    rd_reg(1'b1, rv); chk("R2", "ctl reserved readback", rv, 8'h70);
    wr_reg(1'b0, 8'hC3);
    rd_reg(1'b0, rv); chk("R2", "mode readback", rv, 8'hC3);
    wr_reg(1'b1, 8'h00);

    // R3/R4/R5: undivided reference, prescale 3 written mid-period
    cur_req = "R5";
    wr_reg(1'b0, 8'h0C);
    repeat (12) @(negedge clk);
    cur_req = "R3";
    count(40, ni, nc);
    chk("R3", "int pulses/40 undivided", ni, 40);
    chk("R4", "cpu pulses/40 prs=3", nc, 10);
    cur_req = "R5";
    wr_reg(1'b0, 8'h04);
    repeat (12) @(negedge clk);
    count(40, ni, nc);
    chk("R4", "cpu pulses/40 prs=1", nc, 20);
    wr_reg(1'b0, 8'h0C);
    repeat (12) @(negedge clk);

    // R8/R11: plain wait
    cur_req = "R8";
    pulse_wfi();
    count(20, ni, nc);
    chk("R8", "int pulses in wait", ni, 20);
    chk("R8", "cpu pulses in wait", nc, 0);
    cur_req = "R11";
    wake_up();
    count(40, ni, nc);
    chk("R11", "cpu pulses after wake", nc, 10);

    // R9: low-power wait at base/16
    cur_req = "R9";
    wr_reg(1'b0, 8'hE0);
    wr_reg(1'b1, 8'h01);
    pulse_wfi();
    chk("R9", "low_power_o", int'(low_power_o), 1);
    repeat (40) @(negedge clk);
    count(64, ni, nc);
    chk("R9", "int pulses/64 low power", ni, 2);
    chk("R9", "cpu pulses/64 low power", nc, 0);
    cur_req = "R11";
    wake_up();
    chk("R11", "low_power_o after wake", int'(low_power_o), 0);
    count(20, ni, nc);
    chk("R11", "cpu pulses/20 after lp wake", nc, 10);

    // R6/R7: alternate clock present
    cur_req = "R6";
    wr_reg(1'b1, 8'h00);
    alt_run = 1'b1;
    repeat (80) @(negedge clk);
    cur_req = "R7";
    wr_reg(1'b1, 8'h04);
    repeat (4) @(negedge clk);
    chk("R7", "alt_clk_active with alt toggling", int'(alt_clk_active), 1);
    count(64, ni, nc);
    chk("R7", "int pulses/64 on alt", ni, 8);
    cur_req = "R6";
    alt_run = 1'b0;
    repeat (140) @(negedge clk);
    chk("R6", "alt_clk_active after alt stops", int'(alt_clk_active), 0);
    count(20, ni, nc);
    chk("R7", "int pulses/20 back on reference", ni, 10);

    // R7: select with no alternate present
    cur_req = "R7";
    wr_reg(1'b1, 8'h00);
    wr_reg(1'b1, 8'h04);
    repeat (10) @(negedge clk);
    chk("R7", "alt_clk_active without alt", int'(alt_clk_active), 0);
    count(20, ni, nc);
    chk("R7", "int pulses/20 select w/o alt", ni, 10);

    // R10: low-power wait on alternate, sticky after wake
    cur_req = "R10";
    wr_reg(1'b1, 8'h03);
    alt_run = 1'b1;
    repeat (80) @(negedge clk);
    chk("R10", "alt not used before wait", int'(alt_clk_active), 0);
    pulse_wfi();
    rd_reg(1'b1, rv); chk("R10", "ctl after lp entry", rv, 8'h07);
    chk("R10", "alt used in lp wait", int'(alt_clk_active), 1);
    wake_up();
    repeat (4) @(negedge clk);
    chk("R10", "alt still used after wake", int'(alt_clk_active), 1);
    rd_reg(1'b1, rv); chk("R10", "ctl after wake", rv, 8'h07);
    wr_reg(1'b1, 8'h00);
    chk("R10", "alt released by software", int'(alt_clk_active), 0);
    alt_run = 1'b0;
    repeat (10) @(negedge clk);

    // R12: halt converted to soft reset, then plain halt
    cur_req = "R12";
    wr_reg(1'b1, 8'h08);
    s0 = srst_seen;
    pulse_halt();
    repeat (3) @(negedge clk);
    chk("R12", "soft reset pulses", srst_seen - s0, 1);
    chk("R12", "halted_o with reset enable", int'(halted_o), 0);
    wr_reg(1'b1, 8'h00);
    pulse_halt();
    chk("R12", "halted_o", int'(halted_o), 1);
    count(20, ni, nc);
    chk("R12", "int pulses while halted", ni, 0);
    chk("R12", "cpu pulses while halted", nc, 0);
    do_reset();
    chk("R1", "halted_o cleared by reset", int'(halted_o), 0);

    repeat (5) @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      fail_line("watchdog", "run did not finish", 0, 1);
      summary();
      $finish;
    end
  end

endmodule